// File: doc/BRIEF.md
# DRAM Access/Refresh Mode Arbiter

This block sits between a processor bus and a DRAM controller that offers an automatic access mode and a forced-refresh mode. It keeps the controller in automatic access mode and turns each processor bus cycle into an access strobe. Local cycles also get a controller select. A read strobe falls as soon as the read is seen. A local write strobe is held back by a configurable number of clocks, so that write data is valid ahead of the column strobe. Cycles that do not target this memory still produce a strobe, with the select left off, so that the controller can slip in hidden refreshes.

When the controller raises a refresh request, the arbiter waits for any bus cycle in progress to end. It then switches the controller into forced-refresh mode for a fixed number of clocks. If the processor starts a local access during that time, it receives a wait signal. When the refresh ends, mode and wait drop together. The next strobe is held off for a configurable recovery gap.

Top module: `dram_mode_arbiter`

## Requirements
- R1: After reset, and after a reset applied at any point, the strobe is high and the select, refresh mode and wait are low. A refresh request seen before the reset is dropped.
- R2: A local read seen at a clock edge raises the select at that edge. The strobe falls at the following edge, provided no recovery gap is running.
- R3: A local write raises the select at the first edge, like a read. Its strobe falls WR_DELAY edges later than a read's would.
- R4: A non-local read or write drives the strobe low at the second edge with no write delay. The select stays low.
- R5: At the first edge where neither read nor write is asserted, the strobe returns high and the select drops.
- R6: A refresh request seen while idle raises the refresh mode at that same edge. The mode stays high for exactly RFSH_LEN cycles.
- R7: A refresh request that arrives during a bus cycle is held pending. The mode rises at the edge after the cycle ends. Refresh mode and a low strobe never overlap.
- R8: Wait is high while the refresh mode is high and a local read or write is asserted. It falls at the same edge as the mode. A non-local cycle during refresh never raises wait.
- R9: After the refresh mode falls, a waiting cycle gets its select one edge later. Its strobe does not fall until GAP_CYC further edges have passed (GAP_CYC+1 cycles of recovery in all).
- R10: When a refresh request and a new cycle are seen at the same idle edge, the refresh wins. The cycle is served after the refresh and the recovery gap.
- R11: A cycle withdrawn before its strobe falls returns the block to idle at the next edge. The strobe never falls for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_rd | input | 1 | Processor read cycle active |
| cyc_wr | input | 1 | Processor write cycle active |
| cyc_local | input | 1 | Current cycle targets this DRAM |
| refresh_req | input | 1 | Refresh request pulse from the controller |
| ctl_refresh_mode | output | 1 | 1 selects forced refresh, 0 selects automatic access |
| ctl_strobe_n | output | 1 | Access strobe to the controller, active low |
| ctl_select | output | 1 | Controller select for local cycles |
| cpu_wait | output | 1 | Wait request to the processor |

## Verification
Some properties are checked on every cycle. Refresh mode and a low strobe never overlap, and wait never appears outside refresh mode. Each refresh lasts exactly RFSH_LEN cycles. The recovery gap holds before any strobe falls. A local strobe is always preceded by a cycle of select. A local write spends its delay in setup, and the strobe is released once the request ends. Other properties are shown only by the bench's scenarios: the exact edge at which each output moves, the ordering of a deferred refresh against the end of a cycle, refresh priority on a same-edge collision, a withdrawn cycle, and reset dropping a pending refresh.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETUP  = 2'd1,
    SEQ_ACCESS = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dmarb_refresh_ctl.sv
// Refresh side: pending latch, refresh length timer, recovery gap timer.
module dmarb_refresh_ctl #(
  parameter int RFSH_LEN = 4,
  parameter int GAP_CYC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic refresh_req,
  input  logic grant,
  output logic pending,
  output logic mode_q,
  output logic mode_nxt,
  output logic gap_ok
);
  localparam int LW = $clog2(RFSH_LEN + 1);
  localparam int GW = $clog2(GAP_CYC + 2);

  logic          pend_q;
  logic [LW-1:0] len_cnt;
  logic [GW-1:0] gap_cnt;
  logic          last;

  assign pending  = pend_q | refresh_req;
  assign last     = mode_q && (len_cnt == '0);
  assign mode_nxt = grant | (mode_q & ~last);
  assign gap_ok   = (gap_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      mode_q  <= 1'b0;
      len_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      mode_q <= mode_nxt;
      if (grant)            pend_q <= 1'b0;
      else if (refresh_req) pend_q <= 1'b1;
      if (grant)                        len_cnt <= LW'(RFSH_LEN - 1);
      else if (mode_q && len_cnt != '0) len_cnt <= len_cnt - 1'b1;
      if (last)                gap_cnt <= GW'(GAP_CYC);
      else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
    end
  end

  // run length observer for the refresh duration check
  logic [LW:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst || !mode_q) run_cnt <= '0;
    else                run_cnt <= run_cnt + 1'b1;
  end

  // R6
  refresh_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_q) |-> (run_cnt == (LW+1)'(RFSH_LEN)));

  // R7
  grant_idle_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> !mode_q);
endmodule

// File: rtl/dmarb_access_seq.sv
// Access side: idle / setup / access sequencing of strobe and select.
module dmarb_access_seq
  import dmarb_pkg::*;
#(
  parameter int WR_DELAY = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_rd,
  input  logic cyc_wr,
  input  logic cyc_local,
  input  logic pending,
  input  logic rfsh_busy,
  input  logic gap_ok,
  output logic grant,
  output logic strobe_n_q,
  output logic sel_q
);
  localparam int DW = $clog2(WR_DELAY + 2);
  localparam int AW = $clog2(WR_DELAY + 4) + 1;

  seq_state_e    state_q, state_nxt;
  logic [DW-1:0] dcnt_q, dcnt_nxt;
  logic          loc_q, loc_nxt;
  logic          lwr_q, lwr_nxt;
  logic          req;

  assign req   = cyc_rd | cyc_wr;
  assign grant = (state_q == SEQ_IDLE) && pending && !rfsh_busy;

  always_comb begin
    state_nxt = state_q;
    dcnt_nxt  = dcnt_q;
    loc_nxt   = loc_q;
    lwr_nxt   = lwr_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (!grant && req && !rfsh_busy) begin
          state_nxt = SEQ_SETUP;
          loc_nxt   = cyc_local;
          lwr_nxt   = cyc_wr && cyc_local;
          dcnt_nxt  = (cyc_wr && cyc_local) ? DW'(WR_DELAY) : '0;
        end
      end
      SEQ_SETUP: begin
        if (!req)               state_nxt = SEQ_IDLE;
        else if (dcnt_q != '0)  dcnt_nxt  = dcnt_q - 1'b1;
        else if (gap_ok)        state_nxt = SEQ_ACCESS;
      end
      SEQ_ACCESS: begin
        if (!req) state_nxt = SEQ_IDLE;
      end
      default: state_nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      dcnt_q     <= '0;
      loc_q      <= 1'b0;
      lwr_q      <= 1'b0;
      strobe_n_q <= 1'b1;
      sel_q      <= 1'b0;
    end else begin
      state_q    <= state_nxt;
      dcnt_q     <= dcnt_nxt;
      loc_q      <= loc_nxt;
      lwr_q      <= lwr_nxt;
      strobe_n_q <= (state_nxt != SEQ_ACCESS);
      sel_q      <= (state_nxt != SEQ_IDLE) && loc_nxt;
    end
  end

  // cycles spent in setup, for the write delay check
  logic [AW-1:0] setup_age;
  always_ff @(posedge clk) begin
    if (rst || state_q != SEQ_SETUP)   setup_age <= '0;
    else if (setup_age != '1)          setup_age <= setup_age + 1'b1;
  end

  // R2
  sel_before_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(strobe_n_q) && sel_q) |-> $past(sel_q));

  // R3
  write_delay_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(strobe_n_q) && lwr_q) |-> (setup_age >= AW'(WR_DELAY + 1)));

  // R5
  strobe_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!req && !strobe_n_q) |=> strobe_n_q);
endmodule

// File: rtl/dram_mode_arbiter.sv
module dram_mode_arbiter #(
  parameter int WR_DELAY = 1,
  parameter int GAP_CYC  = 2,
  parameter int RFSH_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_rd,
  input  logic cyc_wr,
  input  logic cyc_local,
  input  logic refresh_req,
  output logic ctl_refresh_mode,
  output logic ctl_strobe_n,
  output logic ctl_select,
  output logic cpu_wait
);
  localparam int SW = $clog2(GAP_CYC + 3);

  logic pending, mode_q, mode_nxt, gap_ok, grant;
  logic wait_q;

  dmarb_refresh_ctl #(.RFSH_LEN(RFSH_LEN), .GAP_CYC(GAP_CYC)) u_rfsh (
    .clk(clk), .rst(rst), .refresh_req(refresh_req), .grant(grant),
    .pending(pending), .mode_q(mode_q), .mode_nxt(mode_nxt), .gap_ok(gap_ok)
  );

  dmarb_access_seq #(.WR_DELAY(WR_DELAY)) u_seq (
    .clk(clk), .rst(rst), .cyc_rd(cyc_rd), .cyc_wr(cyc_wr),
    .cyc_local(cyc_local), .pending(pending), .rfsh_busy(mode_q),
    .gap_ok(gap_ok), .grant(grant), .strobe_n_q(ctl_strobe_n),
    .sel_q(ctl_select)
  );

  always_ff @(posedge clk) begin
    if (rst) wait_q <= 1'b0;
    else     wait_q <= mode_nxt && (cyc_rd || cyc_wr) && cyc_local;
  end

  assign ctl_refresh_mode = mode_q;
  assign cpu_wait         = wait_q;

  // cycles since the refresh mode was last high, saturating
  logic [SW-1:0] since_rfsh;
  always_ff @(posedge clk) begin
    if (rst)                  since_rfsh <= '1;
    else if (mode_q)          since_rfsh <= '0;
    else if (since_rfsh != '1) since_rfsh <= since_rfsh + 1'b1;
  end

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl_refresh_mode && !ctl_strobe_n));

  // R7
  refresh_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_refresh_mode) |-> (ctl_strobe_n && !ctl_select));

  // R8
  wait_in_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wait |-> ctl_refresh_mode);

  // R9
  recovery_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_strobe_n) |-> (since_rfsh >= SW'(GAP_CYC + 1)));
endmodule

// File: tb/tb_dram_mode_arbiter.sv
module tb_dram_mode_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_rd = 1'b0, cyc_wr = 1'b0, cyc_local = 1'b0, refresh_req = 1'b0;
  logic ctl_refresh_mode, ctl_strobe_n, ctl_select, cpu_wait;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_mode_arbiter #(.WR_DELAY(1), .GAP_CYC(2), .RFSH_LEN(4)) dut (
    .clk(clk), .rst(rst), .cyc_rd(cyc_rd), .cyc_wr(cyc_wr),
    .cyc_local(cyc_local), .refresh_req(refresh_req),
    .ctl_refresh_mode(ctl_refresh_mode), .ctl_strobe_n(ctl_strobe_n),
    .ctl_select(ctl_select), .cpu_wait(cpu_wait)
  );

  // {requirement, inputs {rd,wr,local,rfq}, expected {mode,strobe_n,select,wait}}
  localparam logic [11:0] VEC [NVEC] = '{
    12'h2A6, 12'h2A2, 12'h2A2, 12'h504,           // R2 local read, R5 end
    12'h366, 12'h366, 12'h362, 12'h504,           // R3 local write delayed
    12'h444, 12'h440, 12'h504,                    // R4 non-local write
    12'h61C, 12'h8AD, 12'h8AD, 12'h8AD, 12'h8A4,  // R6 refresh, R8 wait
    12'h9A6, 12'h9A6, 12'h9A2,                    // R9 recovery gap
    12'h7B2, 12'h7A2, 12'h704, 12'h70C,           // R7 deferred refresh
    12'h60C, 12'h60C, 12'h60C, 12'h604,           // R6 length
    12'h61C, 12'h88C, 12'h88C, 12'h88C, 12'h884,  // R8 non-local, no wait
    12'h984, 12'h984, 12'h980, 12'h504,           // R9 gap, non-local
    12'hABD, 12'hAAD, 12'hAAD, 12'hAAD, 12'hAA4,  // R10 refresh wins
    12'hAA6, 12'hAA6, 12'hAA2, 12'h504,
    12'hB66, 12'hB04, 12'hB04                     // R11 withdrawn cycle
  };

  task automatic check4(input int req, input logic [3:0] exp);
    logic [3:0] act;
    act = {ctl_refresh_mode, ctl_strobe_n, ctl_select, cpu_wait};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: {mode,strobe_n,sel,wait} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [3:0] in);
    {cyc_rd, cyc_wr, cyc_local, refresh_req} = in;
  endtask

  task automatic step(input logic [3:0] in);
    drive(in);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check4(1, 4'b0100);                // R1 reset state

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][7:4]);
      check4(int'(VEC[i][11:8]), VEC[i][3:0]);
    end

    // R1: reset in the middle of an access returns everything to idle
    step(4'b1010);
    step(4'b1010);
    check4(2, 4'b0010);
    drive(4'b0000);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check4(1, 4'b0100);

    // R1: a refresh left pending by a cycle is dropped by reset
    step(4'b1010);
    step(4'b1010);
    step(4'b1011);
    check4(7, 4'b0010);
    drive(4'b0000);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(4'b0000);
      check4(1, 4'b0100);
    end

    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule